// File: doc/BRIEF.md
# GPIO Bank with Peripheral Function Mux

This block controls a bank of general-purpose I/O pins. Software changes each per-pin attribute through a simple memory-mapped register port. The attributes are controller ownership, output enable, output data, pull-up, pull-down and open-drain drive. Each one has a write-one-to-set address and a write-one-to-clear address. A bit written as 0 changes nothing, so one pin can be altered without a read-modify-write of the whole word. Each attribute also has a status address that reads back its current value.

A pin owned by the controller drives the pad from its own data and enable bits. A pin that is released from the controller forwards one of four peripheral functions to the pad. Two per-pin select bits, held in plain read/write registers, choose the function. The bank also drives the pad pull controls and a per-pin Schmitt-trigger disable. Pad levels pass through a two-stage synchronizer and are readable for every pin, whoever owns the pin.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset every pin is controller-owned and all other attribute bits, select bits, Schmitt-disable bits and the synchronized pad levels are 0. The pads are therefore undriven and have no pulls.
- R2: A write to an attribute's set address (word address 3k) sets exactly the bits written as 1 by the next clock edge. Attribute index k is ownership 0, output enable 1, output data 2, pull-up 3, pull-down 4 and open-drain 5.
- R3: A write to an attribute's clear address (3k+1) clears exactly the bits written as 1. Bits written as 0 keep their value on both set and clear writes.
- R4: The status address 3k+2 returns attribute k combinationally. Writes to status addresses and to the pin-level address 21 change no state.
- R5: Addresses 18 (select low) and 19 (select high) are read/write registers. Function code = {select high bit, select low bit}: 0 is A, 1 is B, 2 is C, 3 is D.
- R6: On an owned pin with open-drain off, the pad output equals the data bit and the pad enable equals the output-enable bit.
- R7: On a pin that is not owned, the pad output and enable come from the selected function's bits. Function f of pin i is bit f*32+i of periph_out and periph_oe.
- R8: With open-drain on, a pin never drives high. The pad output is 0 and the pad enable is on only when the driving value is 0 and the driver is enabled.
- R9: pad_pu follows the pull-up bits. pad_pd is the pull-down bits with any pin that has pull-up set masked off, so the two pulls are never on together.
- R10: Address 20 is a read/write register whose bit i drives pad_st_off[i], where 1 disables the Schmitt trigger on that pin.
- R11: Address 21 returns pad_in delayed by two clock edges, for every pin regardless of ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Asynchronous pad levels |
| periph_out | input | 128 | Output values of functions A..D, 32 bits each |
| periph_oe | input | 128 | Output enables of functions A..D, 32 bits each |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad driver enable |
| pad_pu | output | 32 | Pull-up enable |
| pad_pd | output | 32 | Pull-down enable |
| pad_st_off | output | 32 | Schmitt-trigger disable |

## Verification
The assertions assume that only one register address is addressed per cycle, so a single cycle never sets and clears the same attribute. They also assume that bus_wr is a clean single-cycle strobe sampled on the rising edge. The stimulus changes the bus and pad inputs only on falling edges, issues one write at a time and returns bus_wr to 0 between writes. Pad inputs change only after reset has been released, which keeps the two-edge latency check of the pin-level path meaningful.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int ATTR_N     = 6;
    localparam int A_OWN      = 0;
    localparam int A_OE       = 1;
    localparam int A_DATA     = 2;
    localparam int A_PU       = 3;
    localparam int A_PD       = 4;
    localparam int A_MD       = 5;
    localparam int ADDR_SEL0  = 18;
    localparam int ADDR_SEL1  = 19;
    localparam int ADDR_STOFF = 20;
    localparam int ADDR_LEVEL = 21;
    localparam int FUNC_N     = 4;

    function automatic int set_addr(int k);
        return 3 * k;
    endfunction
    function automatic int clr_addr(int k);
        return 3 * k + 1;
    endfunction
    function automatic int stat_addr(int k);
        return 3 * k + 2;
    endfunction
endpackage

// File: rtl/gpio_attr_reg.sv
module gpio_attr_reg #(
    parameter int NPINS    = 32,
    parameter bit RST_ONES = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] val_q
);
    logic [NPINS-1:0] val_d;

    always_comb begin
        val_d = val_q;
        if (set_stb) val_d = val_q | wdata;
        if (clr_stb) val_d = val_q & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= {NPINS{RST_ONES}};
        else        val_q <= val_d;
    end

    p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((val_q & $past(wdata)) == $past(wdata)));
    p_clr_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((val_q & $past(wdata)) == '0));
    p_zero_bits_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> ((val_q & ~$past(wdata)) == ($past(val_q) & ~$past(wdata))));
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(val_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] level_q
);
    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = pad_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level_q = sync_q.s2;

    // Warm-up counter used only to qualify the latency check below.
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    p_two_edge_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (level_q == $past(pad_in, 2)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]        own,
    input  logic [NPINS-1:0]        oe,
    input  logic [NPINS-1:0]        data,
    input  logic [NPINS-1:0]        pu,
    input  logic [NPINS-1:0]        pd,
    input  logic [NPINS-1:0]        md,
    input  logic [NPINS-1:0]        sel0,
    input  logic [NPINS-1:0]        sel1,
    input  logic [FUNC_N*NPINS-1:0] periph_out,
    input  logic [FUNC_N*NPINS-1:0] periph_oe,
    output logic [NPINS-1:0]        pad_out,
    output logic [NPINS-1:0]        pad_oe,
    output logic [NPINS-1:0]        pad_pu,
    output logic [NPINS-1:0]        pad_pd
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [1:0] fsel;
        logic       pv;
        logic       pe;
        logic       drv_val;
        logic       drv_en;
        assign fsel    = {sel1[i], sel0[i]};
        assign pv      = periph_out[int'(fsel) * NPINS + i];
        assign pe      = periph_oe[int'(fsel) * NPINS + i];
        assign drv_val = own[i] ? data[i] : pv;
        assign drv_en  = own[i] ? oe[i]   : pe;
        assign pad_out[i] = drv_val & ~md[i];
        assign pad_oe[i]  = drv_en & ~(md[i] & drv_val);
    end

    assign pad_pu = pu;
    assign pad_pd = pd & ~pu;
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [NPINS-1:0]        bus_wdata,
    output logic [NPINS-1:0]        bus_rdata,
    input  logic [NPINS-1:0]        pad_in,
    input  logic [FUNC_N*NPINS-1:0] periph_out,
    input  logic [FUNC_N*NPINS-1:0] periph_oe,
    output logic [NPINS-1:0]        pad_out,
    output logic [NPINS-1:0]        pad_oe,
    output logic [NPINS-1:0]        pad_pu,
    output logic [NPINS-1:0]        pad_pd,
    output logic [NPINS-1:0]        pad_st_off
);
    typedef struct packed {
        logic [NPINS-1:0] sel0;
        logic [NPINS-1:0] sel1;
        logic [NPINS-1:0] stoff;
    } rw_t;

    logic [NPINS-1:0] attr_q [ATTR_N];
    logic [NPINS-1:0] level_q;
    rw_t              rw_d, rw_q;

    for (genvar k = 0; k < ATTR_N; k++) begin : g_attr
        gpio_attr_reg #(
            .NPINS   (NPINS),
            .RST_ONES(k == A_OWN)
        ) u_attr (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_stb(bus_wr && (bus_addr == ADDR_W'(set_addr(k)))),
            .clr_stb(bus_wr && (bus_addr == ADDR_W'(clr_addr(k)))),
            .wdata  (bus_wdata),
            .val_q  (attr_q[k])
        );
    end

    always_comb begin
        rw_d = rw_q;
        if (bus_wr) begin
            if (bus_addr == ADDR_W'(ADDR_SEL0))  rw_d.sel0  = bus_wdata;
            if (bus_addr == ADDR_W'(ADDR_SEL1))  rw_d.sel1  = bus_wdata;
            if (bus_addr == ADDR_W'(ADDR_STOFF)) rw_d.stoff = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rw_q <= '0;
        else        rw_q <= rw_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < ATTR_N; k++) begin
            if (bus_addr == ADDR_W'(stat_addr(k))) bus_rdata = attr_q[k];
        end
        if (bus_addr == ADDR_W'(ADDR_SEL0))  bus_rdata = rw_q.sel0;
        if (bus_addr == ADDR_W'(ADDR_SEL1))  bus_rdata = rw_q.sel1;
        if (bus_addr == ADDR_W'(ADDR_STOFF)) bus_rdata = rw_q.stoff;
        if (bus_addr == ADDR_W'(ADDR_LEVEL)) bus_rdata = level_q;
    end

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level_q(level_q)
    );

    gpio_pad_mux #(.NPINS(NPINS)) u_mux (
        .own       (attr_q[A_OWN]),
        .oe        (attr_q[A_OE]),
        .data      (attr_q[A_DATA]),
        .pu        (attr_q[A_PU]),
        .pd        (attr_q[A_PD]),
        .md        (attr_q[A_MD]),
        .sel0      (rw_q.sel0),
        .sel1      (rw_q.sel1),
        .periph_out(periph_out),
        .periph_oe (periph_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd)
    );

    assign pad_st_off = rw_q.stoff;

    p_no_high_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & attr_q[A_MD]) == '0));
    p_owned_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe ^ attr_q[A_OE]) | (pad_out ^ attr_q[A_DATA])) & attr_q[A_OWN] & ~attr_q[A_MD]) == '0);
    p_pulls_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_pd) == '0));
    p_status_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ADDR_LEVEL)) |=> $stable(rw_q));
endmodule

// File: tb/gpio_mux_bank_tb.sv
module gpio_mux_bank_tb;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [4*NP-1:0] periph_out;
    logic [4*NP-1:0] periph_oe;
    logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_st_off;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    // Function A: out0 oe0, B: out1 oe0, C: out0 oe1, D: out1 oe1
    assign periph_out = {{NP{1'b1}}, {NP{1'b0}}, {NP{1'b1}}, {NP{1'b0}}};
    assign periph_oe  = {{NP{1'b1}}, {NP{1'b1}}, {NP{1'b0}}, {NP{1'b0}}};

    gpio_mux_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .periph_out(periph_out), .periph_oe(periph_oe), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_st_off(pad_st_off)
    );

    typedef struct packed {
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ca;
        logic [31:0] ex;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  32'h0000_00FF, 5'd5,  32'h0000_00FF},  // R2 oe set
        '{5'd3,  32'hF000_0000, 5'd5,  32'hF000_00FF},  // R2 oe set, others kept
        '{5'd4,  32'h0000_000F, 5'd5,  32'hF000_00F0},  // R3 oe clear
        '{5'd3,  32'h0000_0000, 5'd5,  32'hF000_00F0},  // R3 zero bits no effect
        '{5'd6,  32'hA5A5_A5A5, 5'd8,  32'hA5A5_A5A5},  // R2 data set
        '{5'd7,  32'hFFFF_0000, 5'd8,  32'h0000_A5A5},  // R3 data clear
        '{5'd1,  32'h0000_FF00, 5'd2,  32'hFFFF_00FF},  // R3 ownership clear
        '{5'd9,  32'h0000_0003, 5'd11, 32'h0000_0003},  // R2 pull-up set
        '{5'd18, 32'h1234_5678, 5'd18, 32'h1234_5678},  // R5 select low
        '{5'd19, 32'h0F0F_0F0F, 5'd19, 32'h0F0F_0F0F},  // R5 select high
        '{5'd20, 32'h8000_0001, 5'd20, 32'h8000_0001},  // R10 schmitt off
        '{5'd15, 32'h0000_0030, 5'd17, 32'h0000_0030},  // R2 open-drain set
        '{5'd5,  32'hFFFF_FFFF, 5'd5,  32'hF000_00F0}   // R4 status write ignored
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'd2, r);  chk("R1 ownership", r, 32'hFFFF_FFFF);
        rd(5'd5, r);  chk("R1 output enable", r, 32'h0);
        rd(5'd21, r); chk("R1 level", r, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_pu", pad_pu, 32'h0);

        for (int v = 0; v < NV; v++) begin
            wr(VECS[v].wa, VECS[v].wd);
            rd(VECS[v].ca, r);
            chk($sformatf("table vector %0d", v), r, VECS[v].ex);
        end

        // R6 owned pins: pin7 drives 1, pin0 undriven
        chk("R6 pad_oe pins 7,0", {30'd0, pad_oe[7], pad_oe[0]}, 32'h2);
        chk("R6 pad_out pin7", {31'd0, pad_out[7]}, 32'h1);
        // R8 pin4 (data 0) drives low, pin5 (data 1) released
        chk("R8 pad_oe pins 5,4", {30'd0, pad_oe[5], pad_oe[4]}, 32'h1);
        chk("R8 pad_out pins 5,4", {30'd0, pad_out[5], pad_out[4]}, 32'h0);
        // R7 pins 8..15 carry functions C,D,D,C,B,A,B,A
        chk("R7 pad_out[15:8]", {24'd0, pad_out[15:8]}, 32'h56);
        chk("R7 pad_oe[15:8]", {24'd0, pad_oe[15:8]}, 32'h0F);
        // R10
        chk("R10 pad_st_off", pad_st_off, 32'h8000_0001);

        // R9 pull-up wins over pull-down
        wr(5'd12, 32'h0000_0006);
        rd(5'd14, r); chk("R9 pd status", r, 32'h6);
        chk("R9 pad_pu", pad_pu, 32'h3);
        chk("R9 pad_pd", pad_pd, 32'h4);
        wr(5'd10, 32'h0000_0002);
        chk("R9 pad_pd after pu clear", pad_pd, 32'h6);

        // R4 write to level address ignored
        wr(5'd21, 32'hFFFF_FFFF);
        rd(5'd18, r); chk("R4 sel0 after level write", r, 32'h1234_5678);

        // R11 two-edge latency, pins 8..15 not owned
        @(negedge clk);
        pad_in = 32'hDEAD_BEEF;
        @(negedge clk);
        rd(5'd21, r); chk("R11 level after one edge", r, 32'h0);
        @(negedge clk);
        rd(5'd21, r); chk("R11 level after two edges", r, 32'hDEAD_BEEF);

        // R1 reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(5'd2, r);  chk("R1 ownership after reset", r, 32'hFFFF_FFFF);
        rd(5'd17, r); chk("R1 open-drain after reset", r, 32'h0);
        rd(5'd19, r); chk("R1 sel1 after reset", r, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule